// File: doc/BRIEF.md
# Load/Store Lane Formatter

This block sits in the memory stage of a 32-bit core, between the execute results and the data memory port. For each issued memory operation it takes a 6-bit opcode, a 32-bit base register value, a 16-bit displacement and the store source register. From these it forms the effective address as the base plus the sign-extended displacement. It decodes the eight memory opcodes and drives a memory request with byte strobes and write data. For stores, the write data is the source value replicated across the byte lanes. A misaligned flag is raised on the same request, but the access is not blocked.

By default the request is registered, so it appears one clock after issue. On a load, the block keeps the access size, the signedness and the low address bits. It then uses them to pick the addressed byte, halfword or word out of the 32-bit read word that memory returns. The result is sign- or zero-extended to 32 bits. Opcodes outside the memory set produce no request.

Top module: `lsu_lane_formatter`

## Requirements
- R1: The request address equals base_i plus disp_i sign-extended to 32 bits, modulo 2^32.
- R2: Opcodes 0x20, 0x21, 0x23, 0x24 and 0x25 are loads (mem_req_o=1, mem_we_o=0). Opcodes 0x28, 0x29 and 0x2b are stores (mem_req_o=1, mem_we_o=1). Any other opcode, or req_valid_i low, gives mem_req_o=0, mem_we_o=0, mem_be_o=0, misalign_o=0.
- R3: Opcode 0x20 returns the byte in lane k = address bits 1:0 (read bits 8k+7:8k), sign-extended to 32 bits.
- R4: Opcode 0x24 returns the same byte lane, zero-extended.
- R5: Opcodes 0x21 (signed) and 0x25 (unsigned) return read bits 15:0 when address bit 1 is 0 and bits 31:16 when it is 1. The result is sign- or zero-extended respectively.
- R6: Opcode 0x23 returns the whole read word unchanged.
- R7: A byte store (0x28) drives mem_be_o = 1 << address[1:0] and write data equal to the low 8 bits of the source repeated in all four lanes.
- R8: A halfword store (0x29) drives mem_be_o = 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. The write data is the low 16 bits of the source repeated twice.
- R9: A word store (0x2b) drives mem_be_o = 4'b1111 with the source as write data.
- R10: misalign_o is 1 for a halfword access (0x21, 0x25, 0x29) with address bit 0 set. It is also 1 for a word access (0x23, 0x2b) with address bits 1:0 nonzero. Otherwise it is 0.
- R11: With REG_REQ=1 the request outputs change one clock after issue. Loads drive mem_be_o=0 and mem_wdata_o=0. During reset all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Issue an operation this cycle |
| opcode_i | input | 6 | Operation code |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| store_src_i | input | 32 | Store source register value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Effective byte address |
| mem_be_o | output | 4 | Byte write strobes |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| misalign_o | output | 1 | Access not aligned to its size |
| mem_rdata_i | input | 32 | Read word returned by memory |
| load_value_o | output | 32 | Extended load result |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, a 16-bit displacement and REG_REQ=1. Those defaults give four byte lanes, so every lane and halfword position of every opcode can be reached. They also expose the one-cycle request latency, so both the registered request and the held load control are exercised. Random base and displacement values reach negative offsets and address wrap-around. Random opcodes reach the non-memory codes, and random read words reach both sign-bit values in every lane.

// File: rtl/lsfmt_pkg.sv
package lsfmt_pkg;
   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_LD_B  = 6'h20;
   localparam logic [OPC_W-1:0] OPC_LD_H  = 6'h21;
   localparam logic [OPC_W-1:0] OPC_LD_W  = 6'h23;
   localparam logic [OPC_W-1:0] OPC_LD_BU = 6'h24;
   localparam logic [OPC_W-1:0] OPC_LD_HU = 6'h25;
   localparam logic [OPC_W-1:0] OPC_ST_B  = 6'h28;
   localparam logic [OPC_W-1:0] OPC_ST_H  = 6'h29;
   localparam logic [OPC_W-1:0] OPC_ST_W  = 6'h2b;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic      mem;
      logic      wr;
      logic      sx;
      acc_size_e size;
   } acc_ctl_t;
endpackage

// File: rtl/lsfmt_decode.sv
module lsfmt_decode
   import lsfmt_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output acc_ctl_t         ctl
);
   always_comb begin
      ctl = '{mem: 1'b0, wr: 1'b0, sx: 1'b0, size: SZ_W};
      case (opcode)
         OPC_LD_B:  ctl = '{mem: 1'b1, wr: 1'b0, sx: 1'b1, size: SZ_B};
         OPC_LD_H:  ctl = '{mem: 1'b1, wr: 1'b0, sx: 1'b1, size: SZ_H};
         OPC_LD_W:  ctl = '{mem: 1'b1, wr: 1'b0, sx: 1'b0, size: SZ_W};
         OPC_LD_BU: ctl = '{mem: 1'b1, wr: 1'b0, sx: 1'b0, size: SZ_B};
         OPC_LD_HU: ctl = '{mem: 1'b1, wr: 1'b0, sx: 1'b0, size: SZ_H};
         OPC_ST_B:  ctl = '{mem: 1'b1, wr: 1'b1, sx: 1'b0, size: SZ_B};
         OPC_ST_H:  ctl = '{mem: 1'b1, wr: 1'b1, sx: 1'b0, size: SZ_H};
         OPC_ST_W:  ctl = '{mem: 1'b1, wr: 1'b1, sx: 1'b0, size: SZ_W};
         default:   ctl = '{mem: 1'b0, wr: 1'b0, sx: 1'b0, size: SZ_W};
      endcase
   end
endmodule

// File: rtl/lsfmt_agen.sv
module lsfmt_agen #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] addr
);
   localparam int EXT_W = ADDR_W - DISP_W;

   generate
      if (EXT_W > 0) begin : g_ext
         assign addr = base + {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_full
         assign addr = base + disp[ADDR_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/lsfmt_store.sv
module lsfmt_store
   import lsfmt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic              mem,
   input  logic              wr,
   input  acc_size_e         size,
   input  logic [LANE_W-1:0] lane,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0] wdata,
   output logic              misal
);
   localparam int LANES  = DATA_W / 8;
   localparam int HALVES = DATA_W / 16;

   logic [LANES-1:0] be_b, be_h;

   assign be_b = LANES'(1) << lane;
   assign be_h = LANES'(3) << (2 * lane[LANE_W-1:1]);

   always_comb begin
      be    = '0;
      wdata = '0;
      if (mem && wr) begin
         case (size)
            SZ_B: begin
               be    = be_b;
               wdata = {LANES{src[7:0]}};
            end
            SZ_H: begin
               be    = be_h;
               wdata = {HALVES{src[15:0]}};
            end
            default: begin
               be    = '1;
               wdata = src;
            end
         endcase
      end
   end

   always_comb begin
      misal = 1'b0;
      if (mem) begin
         case (size)
            SZ_H:    misal = lane[0];
            SZ_W:    misal = |lane;
            default: misal = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/lsfmt_load.sv
module lsfmt_load
   import lsfmt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic [DATA_W-1:0] rdata,
   input  acc_size_e         size,
   input  logic              sx,
   input  logic [LANE_W-1:0] lane,
   output logic [DATA_W-1:0] value
);
   logic [7:0]  byte_sel;
   logic [15:0] half_sel;

   assign byte_sel = rdata[8*lane +: 8];
   assign half_sel = rdata[16*lane[LANE_W-1:1] +: 16];

   always_comb begin
      case (size)
         SZ_B:    value = {{(DATA_W-8){sx & byte_sel[7]}}, byte_sel};
         SZ_H:    value = {{(DATA_W-16){sx & half_sel[15]}}, half_sel};
         default: value = rdata;
      endcase
   end

   // R4: unsigned byte load leaves upper bits clear
   always_comb begin
      if (size == SZ_B && !sx)
         p_zext_byte_r4: assert (value[DATA_W-1:8] == '0);
   end

   // R5: signed halfword result upper bits copy its bit 15
   always_comb begin
      if (size == SZ_H && sx)
         p_sext_half_r5: assert (value[DATA_W-1:16] == {(DATA_W-16){value[15]}});
   end
endmodule

// File: rtl/lsu_lane_formatter.sv
module lsu_lane_formatter
   import lsfmt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int DISP_W  = 16,
   parameter bit REG_REQ = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [OPC_W-1:0]    opcode_i,
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [DISP_W-1:0]   disp_i,
   input  logic [DATA_W-1:0]   store_src_i,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic [DATA_W/8-1:0] mem_be_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   output logic                misalign_o,
   input  logic [DATA_W-1:0]   mem_rdata_i,
   output logic [DATA_W-1:0]   load_value_o
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("lsu_lane_formatter: DATA_W must be 32");
      end
      if (DISP_W < 2 || DISP_W > ADDR_W) begin : g_bad_disp_w
         $error("lsu_lane_formatter: DISP_W must lie in 2..ADDR_W");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("lsu_lane_formatter: ADDR_W must be at least 8");
      end
   endgenerate

   acc_ctl_t            ctl;
   logic                act;
   logic [ADDR_W-1:0]   addr_c;
   logic [LANES-1:0]    be_c;
   logic [DATA_W-1:0]   wd_c;
   logic                mis_c;

   lsfmt_decode u_dec (
      .opcode (opcode_i),
      .ctl    (ctl)
   );

   lsfmt_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
      .base (base_i),
      .disp (disp_i),
      .addr (addr_c)
   );

   assign act = req_valid_i & ctl.mem;

   lsfmt_store #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
      .mem   (act),
      .wr    (ctl.wr),
      .size  (ctl.size),
      .lane  (addr_c[LANE_W-1:0]),
      .src   (store_src_i),
      .be    (be_c),
      .wdata (wd_c),
      .misal (mis_c)
   );

   logic              r_req, r_we, r_mis, r_ld_sx;
   logic [ADDR_W-1:0] r_addr;
   logic [LANES-1:0]  r_be;
   logic [DATA_W-1:0] r_wd;
   acc_size_e         r_size, r_ld_size;
   logic [LANE_W-1:0] r_ld_lane;

   generate
      if (REG_REQ) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r_req     <= 1'b0;
               r_we      <= 1'b0;
               r_mis     <= 1'b0;
               r_addr    <= '0;
               r_be      <= '0;
               r_wd      <= '0;
               r_size    <= SZ_W;
               r_ld_sx   <= 1'b0;
               r_ld_size <= SZ_W;
               r_ld_lane <= '0;
            end else begin
               r_req  <= act;
               r_we   <= act & ctl.wr;
               r_mis  <= mis_c;
               r_addr <= addr_c;
               r_be   <= be_c;
               r_wd   <= wd_c;
               r_size <= ctl.size;
               if (act && !ctl.wr) begin
                  r_ld_sx   <= ctl.sx;
                  r_ld_size <= ctl.size;
                  r_ld_lane <= addr_c[LANE_W-1:0];
               end
            end
         end
      end else begin : g_comb
         always_comb begin
            r_req     = act;
            r_we      = act & ctl.wr;
            r_mis     = mis_c;
            r_addr    = addr_c;
            r_be      = be_c;
            r_wd      = wd_c;
            r_size    = ctl.size;
            r_ld_sx   = ctl.sx;
            r_ld_size = ctl.size;
            r_ld_lane = addr_c[LANE_W-1:0];
         end
      end
   endgenerate

   assign mem_req_o   = r_req;
   assign mem_we_o    = r_we;
   assign mem_addr_o  = r_addr;
   assign mem_be_o    = r_be;
   assign mem_wdata_o = r_wd;
   assign misalign_o  = r_mis;

   lsfmt_load #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
      .rdata (mem_rdata_i),
      .size  (r_ld_size),
      .sx    (r_ld_sx),
      .lane  (r_ld_lane),
      .value (load_value_o)
   );

   // R2: no request means no strobes, no write, no flag
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req_o |-> (mem_be_o == '0 && !mem_we_o && !misalign_o));

   // R11: a read request never strobes or carries data
   p_load_nostrobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o) |-> (mem_be_o == '0 && mem_wdata_o == '0));

   // R7: byte store touches exactly one lane
   p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o && r_size == SZ_B) |-> ($countones(mem_be_o) == 1));

   // R8: halfword store touches exactly two lanes
   p_half_two_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o && r_size == SZ_H) |-> ($countones(mem_be_o) == 2));

   // R9: word store touches every lane
   p_word_all_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o && r_size == SZ_W) |-> (mem_be_o == '1));

   // R10: odd halfword address is flagged
   p_half_misal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && r_size == SZ_H && mem_addr_o[0]) |-> misalign_o);

   generate
      if (REG_REQ) begin : g_reg_chk
         // R1: registered address follows base plus extended displacement
         p_addr_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid_i && ctl.mem) |=>
               (mem_addr_o == $past(base_i) + ADDR_W'($signed($past(disp_i)))));
      end
   endgenerate
endmodule

// File: tb/sim_lsu_lane_formatter.sv
module sim_lsu_lane_formatter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid_i = 1'b0;
   logic [5:0]  opcode_i = '0;
   logic [31:0] base_i = '0;
   logic [15:0] disp_i = '0;
   logic [31:0] store_src_i = '0;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_req_o, mem_we_o, misalign_o;
   logic [31:0] mem_addr_o, mem_wdata_o, load_value_o;
   logic [3:0]  mem_be_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lsu_lane_formatter u0 (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .opcode_i(opcode_i),
      .base_i(base_i), .disp_i(disp_i), .store_src_i(store_src_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .misalign_o(misalign_o),
      .mem_rdata_i(mem_rdata_i), .load_value_o(load_value_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit is_ld(input logic [5:0] op);
      return op == 6'h20 || op == 6'h21 || op == 6'h23 || op == 6'h24 || op == 6'h25;
   endfunction
   function automatic bit is_st(input logic [5:0] op);
      return op == 6'h28 || op == 6'h29 || op == 6'h2b;
   endfunction

   function automatic logic [3:0] exp_be(input logic [5:0] op, input logic [1:0] ln);
      case (op)
         6'h28:   return 4'b0001 << ln;
         6'h29:   return ln[1] ? 4'b1100 : 4'b0011;
         6'h2b:   return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [31:0] exp_wd(input logic [5:0] op, input logic [31:0] s);
      case (op)
         6'h28:   return {4{s[7:0]}};
         6'h29:   return {2{s[15:0]}};
         6'h2b:   return s;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_mis(input logic [5:0] op, input logic [1:0] ln);
      if (op == 6'h21 || op == 6'h25 || op == 6'h29) return ln[0];
      if (op == 6'h23 || op == 6'h2b) return ln != 2'b00;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_ld(input logic [5:0] op, input logic [1:0] ln,
                                          input logic [31:0] rd);
      logic [7:0]  b;
      logic [15:0] h;
      b = rd[8*ln +: 8];
      h = ln[1] ? rd[31:16] : rd[15:0];
      case (op)
         6'h20:   return {{24{b[7]}}, b};
         6'h24:   return {24'h0, b};
         6'h21:   return {{16{h[15]}}, h};
         6'h25:   return {16'h0, h};
         default: return rd;
      endcase
   endfunction

   function automatic string ld_tag(input logic [5:0] op);
      case (op)
         6'h20:   return "R3";
         6'h24:   return "R4";
         6'h21, 6'h25: return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic string st_tag(input logic [5:0] op);
      case (op)
         6'h28:   return "R7";
         6'h29:   return "R8";
         6'h2b:   return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic issue(input bit v, input logic [5:0] op, input logic [31:0] b,
                        input logic [15:0] d, input logic [31:0] s, input logic [31:0] rd);
      logic [31:0] ea;
      bit          live;
      @(negedge clk);
      req_valid_i = v;
      opcode_i    = op;
      base_i      = b;
      disp_i      = d;
      store_src_i = s;
      ea   = b + {{16{d[15]}}, d};
      live = v && (is_ld(op) || is_st(op));
      @(posedge clk);
      #2;
      req_valid_i = 1'b0;
      chk("R2", "req", {31'h0, mem_req_o}, {31'h0, live});
      chk("R2", "we", {31'h0, mem_we_o}, {31'h0, live && is_st(op)});
      if (live) begin
         chk("R1", "addr", mem_addr_o, ea);
         chk(st_tag(op), "be", {28'h0, mem_be_o}, {28'h0, exp_be(op, ea[1:0])});
         chk(st_tag(op), "wdata", mem_wdata_o, exp_wd(op, s));
         chk("R10", "misalign", {31'h0, misalign_o}, {31'h0, exp_mis(op, ea[1:0])});
         if (is_ld(op)) begin
            mem_rdata_i = rd;
            #1;
            chk(ld_tag(op), "load", load_value_o, exp_ld(op, ea[1:0], rd));
         end
      end else begin
         chk("R2", "be idle", {28'h0, mem_be_o}, 32'h0);
         chk("R2", "mis idle", {31'h0, misalign_o}, 32'h0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [5:0] ops [8];
      int unused_seed;
      ops = '{6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b};
      unused_seed = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      chk("R11", "reset req", {31'h0, mem_req_o}, 32'h0);
      chk("R11", "reset be", {28'h0, mem_be_o}, 32'h0);
      chk("R11", "reset wdata", mem_wdata_o, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // every opcode at every lane, both sign-bit patterns
      for (int i = 0; i < 8; i++) begin
         for (int ln = 0; ln < 4; ln++) begin
            issue(1'b1, ops[i], 32'h0000_1000 + ln, 16'h0010, 32'hA5C3_9E81, 32'h80F1_7F92);
            issue(1'b1, ops[i], 32'h0000_2000, 16'(ln), 32'h1234_5678, 32'h7F08_8077);
         end
      end
      // R1: negative displacement and wrap-around
      issue(1'b1, 6'h23, 32'h0000_1000, 16'hFFFC, 32'h0, 32'hDEAD_BEEF);
      issue(1'b1, 6'h2b, 32'hFFFF_FFFE, 16'h0006, 32'hCAFE_0001, 32'h0);
      issue(1'b1, 6'h28, 32'h0000_0000, 16'h8000, 32'h0000_00EE, 32'h0);
      // R2: non-memory codes and valid low
      issue(1'b1, 6'h22, 32'h100, 16'h4, 32'hFFFF_FFFF, 32'h0);
      issue(1'b1, 6'h2a, 32'h100, 16'h4, 32'hFFFF_FFFF, 32'h0);
      issue(1'b1, 6'h00, 32'h100, 16'h4, 32'hFFFF_FFFF, 32'h0);
      issue(1'b1, 6'h3f, 32'h100, 16'h4, 32'hFFFF_FFFF, 32'h0);
      issue(1'b0, 6'h2b, 32'h100, 16'h4, 32'hFFFF_FFFF, 32'h0);
      issue(1'b0, 6'h20, 32'h100, 16'h4, 32'hFFFF_FFFF, 32'h0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [5:0] op;
         if ($urandom_range(0, 4) == 0) op = 6'($urandom);
         else op = ops[$urandom_range(0, 7)];
         issue($urandom_range(0, 7) != 0, op, $urandom, 16'($urandom), $urandom, $urandom);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule